// File: doc/BRIEF.md
# PWM Clock Generator

This block derives two slow clock-enable streams, A and B, from the master clock for the counters of a PWM unit. A free-running binary counter produces eleven power-of-two taps: the master clock divided by 1, 2, 4, 8, and so on up to 1024. Each tap is a one-cycle enable pulse. Each stream picks one tap and feeds it into an 8-bit linear divider. The stream's tick therefore fires once every `divide * 2^tap` master cycles.

Both stream settings are held in one 32-bit configuration word, which is captured when `cfg_load` is pulsed. A stream whose setting is zero or invalid stays silent. The raw taps are also exported, so a channel can take a power-of-two rate directly. Software chooses the divider values for a wanted frequency; the block only applies them.

Top module: `pwm_tick_gen`

## Requirements
- R1: `taps[k]` (k = 0..10) is high in exactly one cycle out of every 2^k. After a load or after reset release, its first high cycle is cycle 2^k-1, where cycle 0 is the cycle that follows the capturing edge. `taps[0]` is high in every cycle.
- R2: An enabled stream with linear value D (1..255) and tap index S (0..10) raises its tick for one cycle every D*2^S cycles.
- R3: Stream A takes `cfg_word[15:0]` and stream B takes `cfg_word[31:16]`. Within each 16-bit field, bits 7:0 hold D and bits 11:8 hold S. Bits 15:12 of each field are ignored.
- R4: A stream whose 16-bit field is all zeros never ticks.
- R5: A stream with D = 0, or with S greater than 10, never ticks.
- R6: A `cfg_load` pulse restarts the tap counter and both linear counters. The first tick of a stream comes in cycle D*2^S after the capturing edge, and neither tick is high in cycle 0.
- R7: While reset is asserted and in the cycle after its release, both ticks are low and `taps` equals 11'h001.
- R8: The two streams are independent: the setting of one stream does not change the tick timing of the other.
- R9: A change of `cfg_word` without `cfg_load` has no effect on the ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture `cfg_word` and restart all counters |
| cfg_word | input | 32 | Settings for both streams (A low half, B high half) |
| taps | output | 11 | Power-of-two enable pulses, bit k = divide by 2^k |
| tick_a | output | 1 | Enable pulse of stream A |
| tick_b | output | 1 | Enable pulse of stream B |

## Verification
The bench measures the cycle index of the first and second tick after each load. An off-by-one in the terminal count, or a tick that is registered one cycle too late, shows up as a first tick at D*2^S±1 or as a wrong spacing.

The bench drives the extreme settings: D = 1 with S = 0 (a tick every cycle), the largest tap, D = 255, and a reload partway through an interval. A design that kept the old count across a reload would fire early.

Invalid fields (zero, D = 0, S = 11) and set bits 12..15 are driven as well. A design that decoded the upper nibble, or indexed past the last tap, would either tick or stretch the period. The bench also changes `cfg_word` without a load and checks that the timing holds.

// File: rtl/pwmck_pkg.sv
package pwmck_pkg;
    // default geometry of the clock generator
    localparam int DEF_DIV_W   = 8;   // linear divider width
    localparam int DEF_SEL_W   = 4;   // tap index width
    localparam int DEF_TAPS    = 11;  // divide by 1 .. 1024
    localparam int DEF_FIELD_W = 16;  // per-stream configuration field
    localparam int N_STREAMS   = 2;
endpackage

// File: rtl/pwmck_prescale.sv
module pwmck_prescale #(
    parameter int TAPS = pwmck_pkg::DEF_TAPS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    output logic [TAPS-1:0] taps
);
    localparam int CW = TAPS - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // tap k pulses when the low k bits of the counter are all ones
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == 0) begin : g_full
            assign taps[k] = 1'b1;
        end else begin : g_div
            assign taps[k] = &st_q.cnt[k-1:0];
        end
    end
endmodule

// File: rtl/pwmck_stream.sv
module pwmck_stream #(
    parameter int DIV_W = pwmck_pkg::DEF_DIV_W,
    parameter int SEL_W = pwmck_pkg::DEF_SEL_W,
    parameter int TAPS  = pwmck_pkg::DEF_TAPS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [DIV_W+SEL_W-1:0] field,
    input  logic [TAPS-1:0]        taps,
    output logic                   tick,
    output logic                   active,
    output logic [SEL_W-1:0]       sel_out
);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(TAPS - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] sel;
        logic             en;
        logic [DIV_W-1:0] lin;
        logic             tick;
    } str_state_t;

    str_state_t       st_d, st_q;
    logic             tap_hit;
    logic [DIV_W-1:0] new_div;
    logic [SEL_W-1:0] new_sel;

    assign new_div = field[DIV_W-1:0];
    assign new_sel = field[DIV_W +: SEL_W];

    always_comb begin
        tap_hit = 1'b0;
        for (int i = 0; i < TAPS; i++) begin
            if (st_q.sel == SEL_W'(i)) begin
                tap_hit = taps[i];
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (load) begin
            st_d.div = new_div;
            st_d.sel = new_sel;
            st_d.en  = (new_div != '0) && (new_sel <= LAST_SEL);
            st_d.lin = '0;
        end else if (st_q.en && tap_hit) begin
            if (st_q.lin == st_q.div - DIV_W'(1)) begin
                st_d.lin  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.lin = st_q.lin + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick    = st_q.tick;
    assign active  = st_q.en;
    assign sel_out = st_q.sel;
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int DIV_W   = pwmck_pkg::DEF_DIV_W,
    parameter int SEL_W   = pwmck_pkg::DEF_SEL_W,
    parameter int TAPS    = pwmck_pkg::DEF_TAPS,
    parameter int FIELD_W = pwmck_pkg::DEF_FIELD_W
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    cfg_load,
    input  logic [FIELD_W*pwmck_pkg::N_STREAMS-1:0] cfg_word,
    output logic [TAPS-1:0]                         taps,
    output logic                                    tick_a,
    output logic                                    tick_b
);
    localparam int NS    = pwmck_pkg::N_STREAMS;
    localparam int USE_W = DIV_W + SEL_W;

    logic [NS-1:0]            stream_tick;
    logic [NS-1:0]            stream_en;
    logic [NS-1:0][SEL_W-1:0] stream_sel;
    logic [NS-1:0]            unused_hi;

    pwmck_prescale #(.TAPS(TAPS)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_load),
        .taps    (taps)
    );

    for (genvar s = 0; s < NS; s++) begin : g_stream
        pwmck_stream #(
            .DIV_W (DIV_W),
            .SEL_W (SEL_W),
            .TAPS  (TAPS)
        ) u_str (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (cfg_load),
            .field   (cfg_word[s*FIELD_W +: USE_W]),
            .taps    (taps),
            .tick    (stream_tick[s]),
            .active  (stream_en[s]),
            .sel_out (stream_sel[s])
        );
        assign unused_hi[s] = ^cfg_word[s*FIELD_W+USE_W +: FIELD_W-USE_W];
    end

    assign tick_a = stream_tick[0];
    assign tick_b = stream_tick[1];
endmodule

// File: rtl/pwm_tick_gen_chk.sv
module pwm_tick_gen_chk #(
    parameter int TAPS  = 11,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load,
    input logic [TAPS-1:0]  taps,
    input logic             tick_a,
    input logic             tick_b,
    input logic             en_a,
    input logic             en_b,
    input logic [SEL_W-1:0] sel_a,
    input logic [SEL_W-1:0] sel_b
);
    logic hit_a, hit_b;
    assign hit_a = |(taps & (TAPS'(1) << sel_a));
    assign hit_b = |(taps & (TAPS'(1) << sel_b));

    for (genvar k = 1; k < TAPS; k++) begin : g_nest
        assert_tap_nest_R1: assert property (@(posedge clk) disable iff (!rst_n)
            taps[k] |-> taps[k-1]);
    end

    assert_tap_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        taps[TAPS-1] |=> !taps[1]);

    assert_tick_src_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_a |-> $past(en_a && hit_a));

    assert_tick_src_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_b |-> $past(en_b && hit_b));

    assert_off_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_a && !en_b) |=> (!tick_a && !tick_b));

    assert_load_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (!tick_a && !tick_b));
endmodule

bind pwm_tick_gen pwm_tick_gen_chk #(.TAPS(TAPS), .SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .taps     (taps),
    .tick_a   (tick_a),
    .tick_b   (tick_b),
    .en_a     (stream_en[0]),
    .en_b     (stream_en[1]),
    .sel_a    (stream_sel[0]),
    .sel_b    (stream_sel[1])
);

// File: tb/sim_pwm_tick_gen.sv
`timescale 1ns/1ps
module sim_pwm_tick_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [10:0] taps;
    logic        tick_a, tick_b;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pwm_tick_gen u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_word (cfg_word),
        .taps     (taps),
        .tick_a   (tick_a),
        .tick_b   (tick_b)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // returns at the negedge after the capturing edge (cycle 0)
    task automatic do_load(input logic [31:0] w);
        @(negedge clk);
        cfg_word = w;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    function automatic logic pick(input int which);
        return (which == 0) ? tick_a : tick_b;
    endfunction

    // scans cycles 0..limit-1; optionally disturbs cfg_word without a load
    task automatic find_ticks(input int which, input int limit, input bit disturb,
                              output int f, output int s, output int cnt);
        f = -1; s = -1; cnt = 0;
        for (int n = 0; n < limit; n++) begin
            if (n > 0) @(negedge clk);
            if (disturb && n == 2) cfg_word = 32'h0101_0101;
            if (pick(which)) begin
                cnt++;
                if (f < 0) f = n;
                else if (s < 0) s = n;
            end
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R7 tick_a in reset", int'(tick_a), 0);
        check("R7 taps in reset", int'(taps), 1);
        rst_n = 1'b1;
        check("R7 tick_b after release", int'(tick_b), 0);
        check("R7 taps after release", int'(taps), 1);
    endtask

    task automatic t_taps;
        int first[11];
        int cnt[11];
        for (int k = 0; k < 11; k++) begin first[k] = -1; cnt[k] = 0; end
        do_load(32'h0);
        for (int n = 0; n < 2048; n++) begin
            if (n > 0) @(negedge clk);
            for (int k = 0; k < 11; k++) begin
                if (taps[k]) begin
                    cnt[k]++;
                    if (first[k] < 0) first[k] = n;
                end
            end
        end
        for (int k = 0; k < 11; k++) begin
            check($sformatf("R1 tap%0d first", k), first[k], (1 << k) - 1);
            check($sformatf("R1 tap%0d count", k), cnt[k], 2048 >> k);
        end
    endtask

    task automatic t_interval(input logic [31:0] w, input int which, input int n_exp, input string tag);
        int f, s, c;
        do_load(w);
        find_ticks(which, 2 * n_exp + 4, 1'b0, f, s, c);
        check({tag, " first tick"}, f, n_exp);
        check({tag, " second tick"}, s, 2 * n_exp);
    endtask

    task automatic t_silent(input logic [31:0] w, input int which, input string tag);
        int f, s, c;
        do_load(w);
        find_ticks(which, 600, 1'b0, f, s, c);
        check({tag, " tick count"}, c, 0);
    endtask

    task automatic t_restart;
        int f, s, c;
        do_load(32'h0000_0004);   // A: D=4 S=0
        @(negedge clk);
        @(negedge clk);
        do_load(32'h0000_0004);
        find_ticks(0, 12, 1'b0, f, s, c);
        check("R6 reload restart first", f, 4);
        check("R6 reload restart second", s, 8);
    endtask

    task automatic t_no_load;
        int f, s, c;
        do_load(32'h0000_0206);   // A: D=6 S=2 -> 24
        find_ticks(0, 60, 1'b1, f, s, c);
        check("R9 first after disturb", f, 24);
        check("R9 second after disturb", s, 48);
        cfg_word = 32'h0;
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_taps();
        t_interval(32'h0005_0203, 0, 12, "R2 A D=3 S=2");
        t_interval(32'h0005_0203, 1, 5, "R8 B D=5 S=0 beside A");
        t_interval(32'h0000_0001, 0, 1, "R2 A D=1 S=0");
        t_interval(32'h0000_0A02, 0, 2048, "R2 A largest tap");
        t_interval(32'h01FF_0000, 1, 510, "R2 B D=255 S=1");
        t_interval(32'h0000_F104, 0, 8, "R3 upper nibble ignored");
        t_interval(32'h0103_0000, 1, 6, "R3 B in high half");
        t_interval(32'h0103_0401, 1, 6, "R8 B unaffected by A");
        t_silent(32'h0003_0000, 0, "R4 zero field A");
        t_silent(32'h0000_0300, 0, "R5 D=0");
        t_silent(32'h0B04_0000, 1, "R5 S=11");
        t_restart();
        t_no_load();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule